// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit floating-point control/status word of a scalar FPU and makes it visible through five control-register indices. Index 31 gives the whole word. Indices 25, 26 and 28 are narrow views onto the same storage: the condition codes, the cause and sticky-flag fields, and the enables with rounding control. Index 0 returns a fixed implementation/revision constant. Reads are combinational through a read index. Writes take effect on the next clock edge.

The arithmetic pipeline reports each finished operation as a 6-bit status vector. The block replaces the cause field with that vector and ORs every cause except unimplemented into the sticky flags. It raises a one-cycle trap pulse when an enabled cause is present or when the unimplemented cause is set. The current rounding mode and flush-to-zero bit are driven out continuously for the datapath.

Word layout:
- rounding mode: bits 1:0
- sticky flags: bits 6:2
- enables: bits 11:7
- cause: bits 17:12
- always-zero: bits 22:18
- condition 0: bit 23
- flush-to-zero: bit 24
- conditions 7..1: bits 31:25

The cause, flags and enables fields share one bit order, from their lowest bit upward: inexact, underflow, overflow, divide-by-zero, invalid. The cause field has a sixth bit at the top for unimplemented.

Top module: `fp_csr_unit`

## Requirements
- R1: While reset is asserted, and on release, the stored word is zero and the trap output is low.
- R2: A read of index 0 returns the parameter IMPL_ID. A write to index 0 leaves the stored word unchanged.
- R3: A write to index 31 stores the data with bits 22:18 forced to zero. A read of index 31 returns the stored word, and bits 22:18 always read zero.
- R4: A read of index 25 returns condition 0 (word bit 23) in bit 0 and conditions 7..1 (word bits 31:25) in bits 7:1, with bits 31:8 zero.
- R5: A write to index 25 sets word bit 23 from data bit 0 and word bits 31:25 from data bits 7:1. No other word bit changes.
- R6: Index 26 reads back word bits 17:12 and 6:2 in the same positions, with every other bit zero. A write to index 26 replaces only those two fields.
- R7: After a write to index 26, trap is high in the following cycle exactly when (data[16:12] & enables) is nonzero or data bit 17 is set.
- R8: Index 28 reads back enables (11:7) and rounding mode (1:0) in place, with flush-to-zero shown at bit 2 and every other bit zero. A write to index 28 replaces enables and rounding mode and sets flush-to-zero (word bit 24) from data bit 2. No other word bit changes.
- R9: On an operation report (op_valid), the cause field becomes op_status in the next cycle. The status bits are mapped as follows:
  - bit 0: inexact
  - bit 1: underflow
  - bit 2: overflow
  - bit 3: divide-by-zero
  - bit 4: invalid
  - bit 5: unimplemented
- R10: After an operation report, trap is high for the next cycle exactly when (op_status[4:0] & enables) is nonzero or op_status[5] is set. Otherwise trap is low in cycles with no report and no index-26 write.
- R11: An operation report ORs op_status[4:0] into the sticky flags. Unimplemented never sets a flag. Flags only clear through writes to index 26 or 31.
- R12: When op_valid and wr_en are high in the same cycle, the operation report is applied and the register write is dropped.
- R13: round_mode equals word bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity) and flush_zero equals word bit 24.
- R14: Reads of any other index return zero, and writes to any other index leave the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_idx | input | 5 | Index written |
| wr_data | input | 32 | Data written |
| rd_idx | input | 5 | Index read |
| rd_data | output | 32 | Combinational read data |
| op_valid | input | 1 | Operation status report strobe |
| op_status | input | 6 | Exception status of the finished operation |
| csr_q | output | 32 | Full stored word |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Current flush-to-zero control |
| trap | output | 1 | One-cycle exception trap pulse |

## Verification
The bench targets the alias views first. It writes condition patterns with distinct bit 0 and bit 7 values, so a design that failed to close the gap, or that shifted the wrong way, returns scrambled condition codes on index 25 or corrupts flush-to-zero at bit 24. It moves flush-to-zero through index 28 in both directions, which catches a design that stores data bit 2 in place and so sets a sticky flag. Operation reports carrying only the unimplemented status must trap with all enables clear and must leave the flags untouched. A report that collides with a register write exposes a design that lets the write win or merges the two.

// File: rtl/fp_csr_unit.sv
module fp_csr_unit #(
  parameter logic [31:0] IMPL_ID = 32'h0000_0A30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic        op_valid,
  input  logic [5:0]  op_status,
  output logic [31:0] csr_q,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic        trap
);
  localparam logic [4:0] IX_IMPL = 5'd0;
  localparam logic [4:0] IX_COND = 5'd25;
  localparam logic [4:0] IX_EXC  = 5'd26;
  localparam logic [4:0] IX_ENA  = 5'd28;
  localparam logic [4:0] IX_FULL = 5'd31;
  localparam logic [31:0] ZERO_MASK = 32'h007C_0000;
  localparam logic [31:0] EXC_MASK  = 32'h0003_F07C;
  localparam logic [31:0] ENA_MASK  = 32'h0000_0F83;

  logic [31:0] csr, csr_n;
  logic        trap_n;
  logic        wr_ok;

  assign wr_ok = wr_en & ~op_valid;

  always_comb begin
    csr_n  = csr;
    trap_n = 1'b0;
    if (op_valid) begin
      csr_n[17:12] = op_status;
      csr_n[6:2]   = csr[6:2] | op_status[4:0];
      trap_n       = (|(op_status[4:0] & csr[11:7])) | op_status[5];
    end else if (wr_ok) begin
      case (wr_idx)
        IX_COND: begin
          csr_n[23]    = wr_data[0];
          csr_n[31:25] = wr_data[7:1];
        end
        IX_EXC: begin
          csr_n  = (csr & ~EXC_MASK) | (wr_data & EXC_MASK);
          trap_n = (|(wr_data[16:12] & csr[11:7])) | wr_data[17];
        end
        IX_ENA: begin
          csr_n     = (csr & ~ENA_MASK) | (wr_data & ENA_MASK);
          csr_n[24] = wr_data[2];
        end
        IX_FULL: csr_n = wr_data & ~ZERO_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr  <= '0;
      trap <= 1'b0;
    end else begin
      csr  <= csr_n;
      trap <= trap_n;
    end
  end

  always_comb begin
    case (rd_idx)
      IX_IMPL: rd_data = IMPL_ID;
      IX_COND: rd_data = {24'd0, csr[31:25], csr[23]};
      IX_EXC:  rd_data = csr & EXC_MASK;
      IX_ENA:  rd_data = (csr & ENA_MASK) | {29'd0, csr[24], 2'b00};
      IX_FULL: rd_data = csr & ~ZERO_MASK;
      default: rd_data = '0;
    endcase
  end

  assign csr_q      = csr;
  assign round_mode = csr[1:0];
  assign flush_zero = csr[24];

  p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[22:18] == 5'd0);

  p_cause_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> csr_q[17:12] == $past(op_status));

  p_unimpl_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_status[5]) |=> trap);

  p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || op_valid) |=> (($past(csr_q[6:2]) & ~csr_q[6:2]) == 5'd0));

  p_impl_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !op_valid && wr_idx == IX_IMPL) |=> $stable(csr_q));

  p_other_idx_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !op_valid && wr_idx != IX_COND && wr_idx != IX_EXC &&
     wr_idx != IX_ENA && wr_idx != IX_FULL) |=> $stable(csr_q));

  p_no_trap_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> !trap);
endmodule

// File: tb/fp_csr_unit_tb_top.sv
`timescale 1ns/100ps
module fp_csr_unit_tb_top;
  localparam logic [31:0] IMPL = 32'h0000_0A30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        op_valid = 1'b0;
  logic [5:0]  op_status = '0;
  logic [31:0] csr_q;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        trap;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] m_csr = '0;
  logic        m_trap = 1'b0;

  always #2.5 clk = ~clk;

  fp_csr_unit #(.IMPL_ID(IMPL)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .op_valid(op_valid), .op_status(op_status),
    .csr_q(csr_q), .round_mode(round_mode), .flush_zero(flush_zero), .trap(trap));

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input int idx);
    logic [31:0] r = '0;
    if (idx == 0) r = IMPL;
    else if (idx == 25) begin
      r[0] = m_csr[23];
      for (int k = 1; k < 8; k++) r[k] = m_csr[24 + k];
    end else if (idx == 26) begin
      for (int k = 0; k < 6; k++) r[12 + k] = m_csr[12 + k];
      for (int k = 0; k < 5; k++) r[2 + k] = m_csr[2 + k];
    end else if (idx == 28) begin
      for (int k = 0; k < 5; k++) r[7 + k] = m_csr[7 + k];
      r[1:0] = m_csr[1:0];
      r[2] = m_csr[24];
    end else if (idx == 31) r = m_csr;
    return r;
  endfunction

  task automatic check_all(input string tag);
    cmp(csr_q, m_csr, {tag, " R3 word"});
    cmp({31'd0, trap}, {31'd0, m_trap}, {tag, " R10 trap"});
    cmp({30'd0, round_mode}, {30'd0, m_csr[1:0]}, {tag, " R13 round_mode"});
    cmp({31'd0, flush_zero}, {31'd0, m_csr[24]}, {tag, " R13 flush_zero"});
    foreach (idx_list[i]) begin
      rd_idx = idx_list[i];
      #0.2;
      cmp(rd_data, model_read(int'(idx_list[i])), $sformatf("%s read idx %0d (R2 R4 R6 R8 R14)", tag, idx_list[i]));
    end
  endtask

  logic [4:0] idx_list [6] = '{5'd0, 5'd25, 5'd26, 5'd28, 5'd31, 5'd9};

  task automatic cycle(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                       input logic ov, input logic [5:0] st, input string tag);
    logic [31:0] n;
    logic t;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; op_valid = ov; op_status = st;
    n = m_csr; t = 1'b0;
    if (ov) begin
      for (int k = 0; k < 6; k++) n[12 + k] = st[k];
      for (int k = 0; k < 5; k++) begin
        if (st[k]) n[2 + k] = 1'b1;
        if (st[k] && m_csr[7 + k]) t = 1'b1;
      end
      if (st[5]) t = 1'b1;
    end else if (we) begin
      if (wi == 25) begin
        n[23] = wd[0];
        for (int k = 1; k < 8; k++) n[24 + k] = wd[k];
      end else if (wi == 26) begin
        for (int k = 0; k < 6; k++) n[12 + k] = wd[12 + k];
        for (int k = 0; k < 5; k++) begin
          n[2 + k] = wd[2 + k];
          if (wd[12 + k] && m_csr[7 + k]) t = 1'b1;
        end
        if (wd[17]) t = 1'b1;
      end else if (wi == 28) begin
        for (int k = 0; k < 5; k++) n[7 + k] = wd[7 + k];
        n[1:0] = wd[1:0];
        n[24] = wd[2];
      end else if (wi == 31) begin
        n = wd;
        for (int k = 18; k < 23; k++) n[k] = 1'b0;
      end
    end
    @(posedge clk);
    #1;
    m_csr = n; m_trap = t;
    wr_en = 1'b0; op_valid = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog expired (R1..)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after release");

    cycle(1, 5'd31, 32'hFFFF_FFFF, 0, 6'd0, "R3 full write ones");
    cycle(1, 5'd0, 32'h1234_5678, 0, 6'd0, "R2 write impl ignored");
    cycle(1, 5'd31, 32'h0000_0000, 0, 6'd0, "R3 clear");
    cycle(1, 5'd25, 32'hFFFF_FF5B, 0, 6'd0, "R5 cond write");
    cycle(1, 5'd25, 32'h0000_0080, 0, 6'd0, "R4 cond top bit");
    cycle(1, 5'd25, 32'h0000_0001, 0, 6'd0, "R4 cond bit0");
    cycle(1, 5'd28, 32'hFFFF_F07C, 0, 6'd0, "R8 ena write fs set rm0");
    cycle(1, 5'd28, 32'h0000_0A83, 0, 6'd0, "R8 ena fs clear rm3");
    cycle(1, 5'd28, 32'h0000_0F86, 0, 6'd0, "R13 rm2 fs set");
    cycle(1, 5'd28, 32'h0000_0001, 0, 6'd0, "R13 rm1");
    cycle(1, 5'd26, 32'hFFFF_FFFF, 0, 6'd0, "R6 R7 exc write no enables unimpl");
    cycle(1, 5'd26, 32'h0000_0000, 0, 6'd0, "R6 exc clear");
    cycle(1, 5'd28, 32'h0000_0200, 0, 6'd0, "R8 enable overflow");
    cycle(1, 5'd26, 32'h0000_4000, 0, 6'd0, "R7 exc write enabled overflow");
    cycle(1, 5'd26, 32'h0000_1000, 0, 6'd0, "R7 exc write non-enabled inexact");
    cycle(0, 5'd0, 32'd0, 1, 6'b000001, "R9 R11 op inexact");
    cycle(0, 5'd0, 32'd0, 1, 6'b100000, "R10 R11 op unimplemented");
    cycle(0, 5'd0, 32'd0, 1, 6'b000100, "R10 op overflow enabled");
    cycle(0, 5'd0, 32'd0, 1, 6'b011010, "R9 R11 op multiple");
    cycle(0, 5'd0, 32'd0, 0, 6'd0, "R10 idle");
    cycle(1, 5'd31, 32'h0000_0000, 1, 6'b000010, "R12 op beats write");
    cycle(1, 5'd7, 32'hFFFF_FFFF, 0, 6'd0, "R14 unused index write");
    cycle(1, 5'd30, 32'hFFFF_FFFF, 0, 6'd0, "R14 index 30 write");
    for (int n = 0; n < 400; n++) begin
      logic [4:0] wi;
      case ($urandom % 7)
        0: wi = 5'd0; 1: wi = 5'd25; 2: wi = 5'd26;
        3: wi = 5'd28; 4: wi = 5'd31; default: wi = 5'($urandom);
      endcase
      cycle(1'($urandom), wi, $urandom, 1'(($urandom % 3) == 0), 6'($urandom),
            "R9 R10 R11 R12 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule